// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block sets the low-power state of a small microcontroller core. Firmware asks for a mode by writing a two-bit power-control word. Bit 0 asks for idle and bit 1 asks for power-down. While the core runs, the block holds the requested mode in a register and turns it into clock-enable levels for four domains: the CPU core, the timer/interrupt logic, the serial port and the oscillator. It also decides whether the external bus strobes and the memory-select line are driven to a fixed level. The clock-gating cells and the oscillator itself are outside this block; it only produces the enables.

Idle stops the core clock and keeps the timer/interrupt and serial domains alive, so that an enabled interrupt can wake the core. Power-down stops every clock, including the oscillator, and only a reset request ends it. That request comes either from the reset pin or from an internal source. The two modes drive the address-latch strobe and the program-store enable to opposite fixed levels. In power-down, memory select is driven inactive unless configuration has turned it into a general-purpose pin. An A/D conversion that is running when idle begins may be corrupted, so the block raises a sticky flag that marks the result as invalid.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_ni` is released, `mode_o` is 2'b00 (run), all four clock enables are 1, no strobe or memory-select forcing is active, and `adc_invalid_o` is 0.
- R2: In run, a write of 2'b01 makes `mode_o` 2'b01 after the clock edge. In idle, `cpu_clk_en_o` is 0 while `tmr_clk_en_o`, `ser_clk_en_o` and `osc_en_o` stay 1.
- R3: In idle, `ale_force_o` and `psen_force_o` are 1 and `ale_level_o` and `psen_level_o` are 1 (strobes held high). Memory select is not forced.
- R4: In idle, if any line has both `irq_req_i` and `irq_en_i` high at a clock edge, `mode_o` returns to 2'b00 after that edge. Requests whose enable is low have no effect.
- R5: In run, a write with bit 1 set makes `mode_o` 2'b10 (power-down) after the edge, and in power-down all four clock enables are 0.
- R6: In power-down, `ale_force_o` and `psen_force_o` are 1 with `ale_level_o` and `psen_level_o` at 0. `memsel_off_o` is 1 when `cfg_memsel_gpio_i` is 0 and is 0 when it is 1.
- R7: Power-down ignores all interrupt requests and ends only when `rst_pin_i` or `rst_int_i` is high at a clock edge, which returns `mode_o` to 2'b00.
- R8: A write of 2'b11 from run enters power-down, not idle.
- R9: Exit from either mode clears both mode bits, so `mode_o` reads 2'b00. `mode_o` never has both bits set.
- R10: Entering idle while `adc_busy_i` is 1 sets `adc_invalid_o` after the edge. Entering idle with `adc_busy_i` at 0 leaves it at 0. A pulse on `adc_start_i` clears it.
- R11: Power-control writes made while in idle or power-down are ignored, because the core is stopped.
- R12: Idle also ends on `rst_pin_i` or `rst_int_i`, and a reset request returns to run even when a write is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pcon_we_i | input | 1 | Power-control write strobe |
| pcon_wdata_i | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| irq_req_i | input | N_IRQ | Interrupt request lines |
| irq_en_i | input | N_IRQ | Per-line interrupt enables |
| rst_pin_i | input | 1 | Synchronous reset request from the reset pin |
| rst_int_i | input | 1 | Internally generated reset request |
| cfg_memsel_gpio_i | input | 1 | 1: memory select is used as general I/O |
| adc_busy_i | input | 1 | A/D conversion in progress |
| adc_start_i | input | 1 | Pulse at start of a new conversion |
| mode_o | output | 2 | Current mode: 00 run, 01 idle, 10 power-down |
| cpu_clk_en_o | output | 1 | Core clock enable |
| tmr_clk_en_o | output | 1 | Timer/interrupt clock enable |
| ser_clk_en_o | output | 1 | Serial port clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| ale_force_o | output | 1 | Address-latch strobe is overridden |
| ale_level_o | output | 1 | Forced address-latch strobe level |
| psen_force_o | output | 1 | Program-store enable is overridden |
| psen_level_o | output | 1 | Forced program-store enable level |
| memsel_off_o | output | 1 | Drive memory select inactive |
| adc_invalid_o | output | 1 | Last conversion may be corrupted |

## Verification
The hardest case to reach is wake-up from idle on a request whose enable is set, when other lines are pending with their enables cleared. A masked request must not wake the core. To cover it, the bench places the block in idle and then applies every combination of request and enable over the four lines for one cycle. It compares the mode with the arithmetic OR of the masked lines. If the block stays in idle, the bench leaves it through a reset request and so covers the reset exit as well. Power-down is checked in the same way: every mode write is made under both configuration settings, every interrupt line is raised while the block is in power-down, and the exit alternates between the two reset sources.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_PD   = 2'b10
  } pwr_mode_e;

  typedef struct packed {
    logic cpu_en;
    logic tmr_en;
    logic ser_en;
    logic osc_en;
    logic ale_force;
    logic ale_level;
    logic psen_force;
    logic psen_level;
    logic memsel_off;
  } pwr_ctl_t;
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             rst_pin_i,
  input  logic             rst_int_i,
  output logic             wake_o,
  output logic             rst_req_o
);
  logic [N_IRQ-1:0] live;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_mask
    assign live[i] = irq_req_i[i] & irq_en_i[i];
  end

  assign wake_o    = |live;
  assign rst_req_o = rst_pin_i | rst_int_i;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rst_req_i,
  input  logic       wake_i,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  output pwr_mode_e  mode_o,
  output logic       idle_entry_o
);
  pwr_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (we_i) begin
          // power-down wins over idle when both bits are written
          if (wdata_i[1])      mode_d = MODE_PD;
          else if (wdata_i[0]) mode_d = MODE_IDLE;
        end
      end
      MODE_IDLE: if (wake_i) mode_d = MODE_RUN;
      MODE_PD:   mode_d = MODE_PD;
      default:   mode_d = MODE_RUN;
    endcase
    if (rst_req_i) mode_d = MODE_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else         mode_q <= mode_d;
  end

  assign mode_o       = mode_q;
  assign idle_entry_o = (mode_q == MODE_RUN) && (mode_d == MODE_IDLE);
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
  import pwr_pkg::*;
(
  input  pwr_mode_e mode_i,
  input  logic      memsel_gpio_i,
  output pwr_ctl_t  ctl_o
);
  always_comb begin
    ctl_o = '{cpu_en: 1'b1, tmr_en: 1'b1, ser_en: 1'b1, osc_en: 1'b1,
              ale_force: 1'b0, ale_level: 1'b0,
              psen_force: 1'b0, psen_level: 1'b0, memsel_off: 1'b0};
    unique case (mode_i)
      MODE_IDLE: begin
        ctl_o.cpu_en     = 1'b0;
        ctl_o.ale_force  = 1'b1;
        ctl_o.ale_level  = 1'b1;
        ctl_o.psen_force = 1'b1;
        ctl_o.psen_level = 1'b1;
      end
      MODE_PD: begin
        ctl_o.cpu_en     = 1'b0;
        ctl_o.tmr_en     = 1'b0;
        ctl_o.ser_en     = 1'b0;
        ctl_o.osc_en     = 1'b0;
        ctl_o.ale_force  = 1'b1;
        ctl_o.psen_force = 1'b1;
        ctl_o.memsel_off = !memsel_gpio_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adc_guard.sv
module adc_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_entry_i,
  input  logic busy_i,
  input  logic start_i,
  output logic invalid_o
);
  logic inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    inv_q <= 1'b0;
    else if (idle_entry_i & busy_i) inv_q <= 1'b1;
    else if (start_i)               inv_q <= 1'b0;
  end

  assign invalid_o = inv_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pcon_we_i,
  input  logic [1:0]       pcon_wdata_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             rst_pin_i,
  input  logic             rst_int_i,
  input  logic             cfg_memsel_gpio_i,
  input  logic             adc_busy_i,
  input  logic             adc_start_i,
  output logic [1:0]       mode_o,
  output logic             cpu_clk_en_o,
  output logic             tmr_clk_en_o,
  output logic             ser_clk_en_o,
  output logic             osc_en_o,
  output logic             ale_force_o,
  output logic             ale_level_o,
  output logic             psen_force_o,
  output logic             psen_level_o,
  output logic             memsel_off_o,
  output logic             adc_invalid_o
);
  logic      wake, rst_req, idle_entry;
  pwr_mode_e mode;
  pwr_ctl_t  ctl;

  pwr_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_req_i (irq_req_i),
    .irq_en_i  (irq_en_i),
    .rst_pin_i (rst_pin_i),
    .rst_int_i (rst_int_i),
    .wake_o    (wake),
    .rst_req_o (rst_req)
  );

  pwr_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rst_req_i    (rst_req),
    .wake_i       (wake),
    .we_i         (pcon_we_i),
    .wdata_i      (pcon_wdata_i),
    .mode_o       (mode),
    .idle_entry_o (idle_entry)
  );

  pwr_out_decode u_dec (
    .mode_i        (mode),
    .memsel_gpio_i (cfg_memsel_gpio_i),
    .ctl_o         (ctl)
  );

  adc_guard u_adc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idle_entry_i (idle_entry),
    .busy_i       (adc_busy_i),
    .start_i      (adc_start_i),
    .invalid_o    (adc_invalid_o)
  );

  assign mode_o       = mode;
  assign cpu_clk_en_o = ctl.cpu_en;
  assign tmr_clk_en_o = ctl.tmr_en;
  assign ser_clk_en_o = ctl.ser_en;
  assign osc_en_o     = ctl.osc_en;
  assign ale_force_o  = ctl.ale_force;
  assign ale_level_o  = ctl.ale_level;
  assign psen_force_o = ctl.psen_force;
  assign psen_level_o = ctl.psen_level;
  assign memsel_off_o = ctl.memsel_off;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int N_IRQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pcon_we_i,
  input logic [1:0]       pcon_wdata_i,
  input logic [N_IRQ-1:0] irq_req_i,
  input logic [N_IRQ-1:0] irq_en_i,
  input logic             rst_pin_i,
  input logic             rst_int_i,
  input logic             cfg_memsel_gpio_i,
  input logic             adc_busy_i,
  input logic             adc_start_i,
  input logic [1:0]       mode_o,
  input logic             cpu_clk_en_o,
  input logic             tmr_clk_en_o,
  input logic             ser_clk_en_o,
  input logic             osc_en_o,
  input logic             ale_force_o,
  input logic             ale_level_o,
  input logic             psen_force_o,
  input logic             psen_level_o,
  input logic             memsel_off_o,
  input logic             adc_invalid_o
);
  logic rst_any;
  assign rst_any = rst_pin_i | rst_int_i;

  p_idle_clocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b01 |-> !cpu_clk_en_o && tmr_clk_en_o && ser_clk_en_o && osc_en_o);

  p_idle_strobes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b01 |-> ale_force_o && ale_level_o && psen_force_o && psen_level_o && !memsel_off_o);

  p_idle_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && |(irq_req_i & irq_en_i)) |=> mode_o == 2'b00);

  p_pd_clocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b10 |-> !cpu_clk_en_o && !tmr_clk_en_o && !ser_clk_en_o && !osc_en_o);

  p_pd_strobes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b10 |-> ale_force_o && !ale_level_o && psen_force_o && !psen_level_o
                        && (memsel_off_o == !cfg_memsel_gpio_i));

  p_pd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10 && !rst_any) |=> mode_o == 2'b10);

  p_both_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && pcon_we_i && pcon_wdata_i == 2'b11 && !rst_any) |=> mode_o == 2'b10);

  p_mode_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mode_o));

  p_adc_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && pcon_we_i && pcon_wdata_i == 2'b01 && adc_busy_i && !rst_any)
    |=> adc_invalid_o);

  p_reset_exit_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_any |=> mode_o == 2'b00);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int N = 4;

  logic clk = 0, rst_ni = 0;
  logic pcon_we = 0;
  logic [1:0] pcon_wdata = 0;
  logic [N-1:0] irq_req = 0, irq_en = 0;
  logic rst_pin = 0, rst_int = 0, cfg_gpio = 0, adc_busy = 0, adc_start = 0;
  logic [1:0] mode;
  logic cpu_en, tmr_en, ser_en, osc_en, ale_f, ale_l, psen_f, psen_l, ms_off, adc_inv;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.N_IRQ(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pcon_we_i(pcon_we), .pcon_wdata_i(pcon_wdata),
    .irq_req_i(irq_req), .irq_en_i(irq_en), .rst_pin_i(rst_pin), .rst_int_i(rst_int),
    .cfg_memsel_gpio_i(cfg_gpio), .adc_busy_i(adc_busy), .adc_start_i(adc_start),
    .mode_o(mode), .cpu_clk_en_o(cpu_en), .tmr_clk_en_o(tmr_en), .ser_clk_en_o(ser_en),
    .osc_en_o(osc_en), .ale_force_o(ale_f), .ale_level_o(ale_l), .psen_force_o(psen_f),
    .psen_level_o(psen_l), .memsel_off_o(ms_off), .adc_invalid_o(adc_inv)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {cpu,tmr,ser,osc,ale_f,ale_l,psen_f,psen_l,ms_off}
  function automatic logic [8:0] exp_out(input logic [1:0] m, input logic g);
    case (m)
      2'b01:   return 9'b0111_1111_0;
      2'b10:   return {8'b0000_1010, !g};
      default: return 9'b1111_0000_0;
    endcase
  endfunction

  function automatic logic [8:0] act_out();
    return {cpu_en, tmr_en, ser_en, osc_en, ale_f, ale_l, psen_f, psen_l, ms_off};
  endfunction

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] v);
    pcon_we = 1; pcon_wdata = v;
    tick();
    pcon_we = 0; pcon_wdata = 0;
  endtask

  task automatic rst_req(input bit use_pin);
    if (use_pin) rst_pin = 1; else rst_int = 1;
    tick();
    rst_pin = 0; rst_int = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] em;
    #35 rst_ni = 1;
    tick();
    // R1 reset state
    check("R1 mode", mode, 2'b00);
    check("R1 outputs", act_out(), exp_out(2'b00, 0));
    check("R1 adc flag", adc_inv, 0);

    // mode writes under both configurations (R2 R3 R5 R6 R8 R11 R7 R9)
    for (int g = 0; g < 2; g++) begin
      for (int w = 0; w < 4; w++) begin
        cfg_gpio = g[0];
        wr(w[1:0]);
        em = w[1] ? 2'b10 : (w[0] ? 2'b01 : 2'b00);
        check(w == 3 ? "R8 mode" : (w[1] ? "R5 mode" : "R2 mode"), mode, em);
        check(em == 2'b10 ? "R6 outputs" : "R3 outputs", act_out(), exp_out(em, g[0]));
        if (em != 2'b00) begin
          // R11 writes while stopped are ignored
          wr(em == 2'b10 ? 2'b01 : 2'b10);
          check("R11 write ignored", mode, em);
          if (em == 2'b10) begin
            irq_req = '1; irq_en = '1;
            tick(); tick();
            irq_req = 0; irq_en = 0;
            check("R7 irq ignored in pd", mode, 2'b10);
          end
          rst_req(w[0] ^ g[0]);
          check("R9 bits cleared on reset exit", mode, 2'b00);
          check("R1 outputs after exit", act_out(), exp_out(2'b00, g[0]));
        end
      end
    end

    // R12 reset beats concurrent write
    pcon_we = 1; pcon_wdata = 2'b10; rst_int = 1;
    tick();
    pcon_we = 0; pcon_wdata = 0; rst_int = 0;
    check("R12 reset over write", mode, 2'b00);

    // R4 exhaustive wake sweep
    for (int r = 0; r < 16; r++) begin
      for (int e = 0; e < 16; e++) begin
        wr(2'b01);
        irq_req = r[N-1:0]; irq_en = e[N-1:0];
        tick();
        irq_req = 0; irq_en = 0;
        em = ((r & e) != 0) ? 2'b00 : 2'b01;
        check("R4 wake", mode, em);
        if (em == 2'b01) begin
          rst_req(e[0]);
          check("R12 idle reset exit", mode, 2'b00);
        end
      end
    end

    // R10 ADC invalid flag
    adc_busy = 0;
    wr(2'b01);
    check("R10 no flag when idle", adc_inv, 0);
    rst_req(1);
    adc_busy = 1;
    wr(2'b01);
    check("R10 flag set", adc_inv, 1);
    irq_req = 1; irq_en = 1;
    tick();
    irq_req = 0; irq_en = 0;
    check("R10 flag sticky after wake", adc_inv, 1);
    check("R9 bits cleared on wake", mode, 2'b00);
    adc_busy = 0; adc_start = 1;
    tick();
    adc_start = 0;
    check("R10 flag cleared by start", adc_inv, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule